// File: doc/BRIEF.md
# Histogram Peak Picker (Top-N Centre Candidates)

This block takes a one-dimensional vote histogram that arrives one bin per clock as a (coordinate, count) pair. It finds the circle-centre candidates along one axis. Each bin is tested against a neighbourhood of `F/2` bins on each side, and only strict local maxima are kept. This is non-maximum suppression sized to the minimum allowed spacing between centres. The surviving maxima enter a ranking chain of `NC` slots. In that chain a larger maximum displaces a smaller one, and the displaced entry moves on toward the far end, so the largest `NC` maxima are the ones that remain.

A pulse on `start` clears all state and opens a new stream. Bins are offered with `in_valid`, and the final bin carries `in_last`. The block then flushes its window with `F/2` zero bins and gives the chain `NC` cycles to settle. After that it raises `done` and presents the candidates as a parallel vector, largest first. One instance serves the x axis and another serves the y axis. Pairing the two candidate sets is done outside this block.

Top module: `pkp_top`

## Requirements
- R1: A bin becomes a maximum only if its count is non-zero and it wins against every bin within HALF = F/2 positions on either side. Positions before the first bin and after the last bin count as zero, so a peak on the first or last bin is reported.
- R2: Of two non-zero peaks at most HALF bins apart, only the one with more votes survives. Peaks more than HALF bins apart both survive.
- R3: Ties go to the lower coordinate. A bin must exceed every earlier bin in its window and must be at least as large as every later one, so a flat plateau yields exactly one maximum, at its first bin.
- R4: After the stream, slot 0 holds the largest maximum, and the counts do not increase with slot index. Of two maxima with equal count, the one seen earlier takes the lower slot. Slot i is carried at out_coord[i*CW +: CW], out_count[i*VW +: VW] and out_valid[i].
- R5: A slot that received no maximum shows valid 0, count 0 and coordinate 0.
- R6: `done` rises exactly HALF+NC clock edges after the edge that accepts the bin marked `in_last`.
- R7: While `done` is high and `start` is low, `done` stays high and all slot outputs hold their values.
- R8: After reset, and in the cycle after a `start` edge, `done` is 0 and every slot is invalid.
- R9: Cycles with `in_valid` low do not advance the window. Bins offered while no stream is open (idle, or after `done`) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clears state and opens a new stream |
| in_valid | input | 1 | A histogram bin is present this cycle |
| in_last | input | 1 | The present bin is the last one of the stream |
| in_coord | input | CW | Coordinate of the present bin |
| in_count | input | VW | Vote count of the present bin |
| done | output | 1 | Candidate slots are final |
| out_valid | output | NC | Per-slot valid flags |
| out_coord | output | NC*CW | Slot coordinates, slot 0 in the low bits |
| out_count | output | NC*VW | Slot counts, slot 0 in the low bits |

## Verification
The bench compares the slots against a reference ranking computed from the same histogram. It targets peaks sitting on the first and last bins. A design that failed to pad with zeros would lose these peaks, or would use stale window contents in their place. Peaks exactly HALF+1 apart must both survive, while peaks ten bins apart must collapse to one. An off-by-one in the window would merge the first pair or keep both of the second. A long plateau and two far-apart peaks of equal height exercise the tie rule. A tie rule that is wrong would report several plateau bins, or would swap the equal peaks in the slot order. Bubbles carrying junk counts, bins offered after `done`, and the exact cycle of `done` catch a window that shifts on idle cycles and a flush or settle period that is too short.

// File: rtl/pkp_pkg.sv
package pkp_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RUN,
        PH_FLUSH,
        PH_SETTLE,
        PH_DONE
    } phase_e;

    function automatic int unsigned larger_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pkp_window.sv
// Sliding neighbourhood of 2*HALF+1 bins; the centre is tested against both sides.
module pkp_window #(
    parameter int unsigned HALF = 20,
    parameter int unsigned CW   = 11,
    parameter int unsigned VW   = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          shift,
    input  logic          in_live,
    input  logic [VW-1:0] in_cnt,
    input  logic [CW-1:0] in_crd,
    output logic          cand_valid,
    output logic [VW-1:0] cand_cnt,
    output logic [CW-1:0] cand_crd
);
    localparam int unsigned WIN = 2 * HALF + 1;

    typedef struct packed {
        logic          live;
        logic [VW-1:0] cnt;
        logic [CW-1:0] crd;
    } bin_t;

    typedef struct packed {
        bin_t [WIN-1:0] win;   // index 0 = newest bin
        logic           fresh; // window moved on the last edge
    } state_t;

    state_t s_q, s_d;

    always_comb begin
        s_d       = s_q;
        s_d.fresh = 1'b0;
        if (clear) begin
            s_d = '0;
        end else if (shift) begin
            s_d.fresh       = 1'b1;
            s_d.win[0].live = in_live;
            s_d.win[0].cnt  = in_live ? in_cnt : '0;
            s_d.win[0].crd  = in_live ? in_crd : '0;
            for (int i = 1; i < WIN; i++) begin
                s_d.win[i] = s_q.win[i-1];
            end
        end
    end

    // Centre must be >= every later bin and > every earlier bin.
    logic is_peak;
    bin_t ctr;
    always_comb begin
        ctr     = s_q.win[HALF];
        is_peak = s_q.fresh && ctr.live && (ctr.cnt != '0);
        for (int i = 0; i < HALF; i++) begin
            if (s_q.win[i].cnt > ctr.cnt) is_peak = 1'b0;
        end
        for (int i = HALF + 1; i < WIN; i++) begin
            if (s_q.win[i].cnt >= ctr.cnt) is_peak = 1'b0;
        end
    end

    assign cand_valid = is_peak;
    assign cand_cnt   = ctr.cnt;
    assign cand_crd   = ctr.crd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/pkp_rank_chain.sv
// Systolic top-N: each slot keeps the best traveller it has seen and passes the loser on.
module pkp_rank_chain #(
    parameter int unsigned NC = 4,
    parameter int unsigned CW = 11,
    parameter int unsigned VW = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             t_valid,
    input  logic [VW-1:0]    t_cnt,
    input  logic [CW-1:0]    t_crd,
    output logic [NC-1:0]    slot_valid,
    output logic [NC*VW-1:0] slot_cnt,
    output logic [NC*CW-1:0] slot_crd
);
    typedef struct packed {
        logic          valid;
        logic [VW-1:0] cnt;
        logic [CW-1:0] crd;
    } entry_t;

    typedef struct packed {
        entry_t [NC-1:0] held;
        entry_t [NC-2:0] pass;
    } state_t;

    state_t s_q, s_d;

    function automatic logic takes(input entry_t t, input entry_t h);
        return t.valid && (!h.valid || (t.cnt > h.cnt));
    endfunction

    entry_t trav [NC];

    always_comb begin
        trav[0].valid = t_valid;
        trav[0].cnt   = t_valid ? t_cnt : '0;
        trav[0].crd   = t_valid ? t_crd : '0;
        for (int i = 1; i < NC; i++) begin
            trav[i] = s_q.pass[i-1];
        end
    end

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d = '0;
        end else begin
            for (int i = 0; i < NC; i++) begin
                if (takes(trav[i], s_q.held[i])) s_d.held[i] = trav[i];
            end
            for (int i = 0; i < NC - 1; i++) begin
                s_d.pass[i] = takes(trav[i], s_q.held[i]) ? s_q.held[i] : trav[i];
            end
        end
    end

    for (genvar g = 0; g < NC; g++) begin : g_slot
        assign slot_valid[g]            = s_q.held[g].valid;
        assign slot_cnt[g*VW +: VW]     = s_q.held[g].cnt;
        assign slot_crd[g*CW +: CW]     = s_q.held[g].crd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/pkp_top.sv
module pkp_top #(
    parameter int unsigned F  = 40,
    parameter int unsigned NC = 4,
    parameter int unsigned CW = 11,
    parameter int unsigned VW = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [CW-1:0]    in_coord,
    input  logic [VW-1:0]    in_count,
    output logic             done,
    output logic [NC-1:0]    out_valid,
    output logic [NC*CW-1:0] out_coord,
    output logic [NC*VW-1:0] out_count
);
    import pkp_pkg::*;

    localparam int unsigned HALF = F / 2;
    localparam int unsigned CMAX = larger_of(HALF, NC);
    localparam int unsigned CTW  = $clog2(CMAX + 1);

    typedef struct packed {
        phase_e         ph;
        logic [CTW-1:0] cnt;
    } ctl_t;

    ctl_t c_q, c_d;
    logic shift, live;

    always_comb begin
        c_d   = c_q;
        shift = 1'b0;
        live  = 1'b0;
        if (start) begin
            c_d.ph  = PH_RUN;
            c_d.cnt = '0;
        end else begin
            case (c_q.ph)
                PH_RUN: begin
                    if (in_valid) begin
                        shift = 1'b1;
                        live  = 1'b1;
                        if (in_last) begin
                            c_d.ph  = PH_FLUSH;
                            c_d.cnt = '0;
                        end
                    end
                end
                PH_FLUSH: begin
                    shift = 1'b1;
                    if (c_q.cnt == CTW'(HALF - 1)) begin
                        c_d.ph  = PH_SETTLE;
                        c_d.cnt = '0;
                    end else begin
                        c_d.cnt = c_q.cnt + 1'b1;
                    end
                end
                PH_SETTLE: begin
                    if (c_q.cnt == CTW'(NC - 1)) begin
                        c_d.ph  = PH_DONE;
                        c_d.cnt = '0;
                    end else begin
                        c_d.cnt = c_q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{ph: PH_IDLE, cnt: '0};
        else        c_q <= c_d;
    end

    logic          cand_valid;
    logic [VW-1:0] cand_cnt;
    logic [CW-1:0] cand_crd;

    pkp_window #(.HALF(HALF), .CW(CW), .VW(VW)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start),
        .shift      (shift),
        .in_live    (live),
        .in_cnt     (in_count),
        .in_crd     (in_coord),
        .cand_valid (cand_valid),
        .cand_cnt   (cand_cnt),
        .cand_crd   (cand_crd)
    );

    pkp_rank_chain #(.NC(NC), .CW(CW), .VW(VW)) u_rank (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start),
        .t_valid    (cand_valid),
        .t_cnt      (cand_cnt),
        .t_crd      (cand_crd),
        .slot_valid (out_valid),
        .slot_cnt   (out_count),
        .slot_crd   (out_coord)
    );

    assign done = (c_q.ph == PH_DONE);

endmodule

// File: rtl/pkp_top_chk.sv
module pkp_top_chk #(
    parameter int unsigned NC = 4,
    parameter int unsigned CW = 11,
    parameter int unsigned VW = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             done,
    input logic [NC-1:0]    out_valid,
    input logic [NC*CW-1:0] out_coord,
    input logic [NC*VW-1:0] out_count
);
    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_done_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> ($stable(out_valid) && $stable(out_coord) && $stable(out_count)));

    p_start_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!done && (out_valid == '0)));

    for (genvar g = 0; g < NC - 1; g++) begin : g_ord
        p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[g+1] |-> (out_valid[g] &&
                (out_count[g*VW +: VW] >= out_count[(g+1)*VW +: VW])));
    end

    for (genvar g = 0; g < NC; g++) begin : g_slot
        p_empty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid[g] |-> ((out_count[g*VW +: VW] == '0) && (out_coord[g*CW +: CW] == '0)));
        p_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[g] |-> (out_count[g*VW +: VW] != '0));
    end
endmodule

bind pkp_top pkp_top_chk #(.NC(NC), .CW(CW), .VW(VW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .out_valid (out_valid),
    .out_coord (out_coord),
    .out_count (out_count)
);

// File: tb/pkp_top_test.sv
`timescale 1ns/1ps
module pkp_top_test;
    localparam int F = 40, NC = 4, CW = 11, VW = 12;
    localparam int HALF = F / 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_last = 1'b0;
    logic [CW-1:0]    in_coord = '0;
    logic [VW-1:0]    in_count = '0;
    logic             done;
    logic [NC-1:0]    out_valid;
    logic [NC*CW-1:0] out_coord;
    logic [NC*VW-1:0] out_count;

    always #2 clk = ~clk;

    pkp_top #(.F(F), .NC(NC), .CW(CW), .VW(VW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_last(in_last), .in_coord(in_coord), .in_count(in_count),
        .done(done), .out_valid(out_valid), .out_coord(out_coord), .out_count(out_count)
    );

    int n_chk = 0, n_bad = 0;
    int hist [0:511];
    int L;
    int exp_crd [NC];
    int exp_cnt [NC];
    int exp_val [NC];

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_hist(input int len);
        L = len;
        for (int j = 0; j < 512; j++) hist[j] = 0;
    endtask

    task automatic model_insert(input int crd, input int cnt);
        bit placed = 0;
        for (int s = 0; s < NC; s++) begin
            if (!placed && (exp_val[s] == 0 || cnt > exp_cnt[s])) begin
                for (int k = NC - 1; k > s; k--) begin
                    exp_val[k] = exp_val[k-1];
                    exp_cnt[k] = exp_cnt[k-1];
                    exp_crd[k] = exp_crd[k-1];
                end
                exp_val[s] = 1; exp_cnt[s] = cnt; exp_crd[s] = crd;
                placed = 1;
            end
        end
    endtask

    // Reference: R1 window rule, R3 tie rule, R4 stable ranking
    task automatic build_model();
        for (int s = 0; s < NC; s++) begin
            exp_val[s] = 0; exp_cnt[s] = 0; exp_crd[s] = 0;
        end
        for (int j = 0; j < L; j++) begin
            bit pk = (hist[j] > 0);
            for (int d = 1; d <= HALF; d++) begin
                if (j - d >= 0 && hist[j-d] >= hist[j]) pk = 0;
                if (j + d < L && hist[j+d] > hist[j]) pk = 0;
            end
            if (pk) model_insert(j, hist[j]);
        end
    endtask

    task automatic check_slots(input string tag);
        for (int s = 0; s < NC; s++) begin
            check({tag, " R4/R5 valid"}, int'(out_valid[s]), exp_val[s]);
            check({tag, " R4/R5 count"}, int'(out_count[s*VW +: VW]), exp_cnt[s]);
            check({tag, " R4/R5 coord"}, int'(out_coord[s*CW +: CW]), exp_crd[s]);
        end
    endtask

    // Opens a stream, feeds hist[0..L-1], checks done timing (R6) and the slots.
    task automatic run_stream(input int gap, input string tag);
        build_model();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int j = 0; j < L; j++) begin
            if (gap > 0 && (j % gap) == 1) begin
                in_valid = 1'b0; in_last = 1'b1;
                in_count = '1;   in_coord = '1;   // junk on a bubble, R9
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_coord = CW'(j);
            in_count = VW'(hist[j]);
            in_last  = (j == L - 1);
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0; in_count = '0; in_coord = '0;
        for (int t = 1; t <= HALF + NC; t++) begin
            @(negedge clk);
            if (t == HALF + NC - 1) check({tag, " R6 done early"}, int'(done), 0);
            if (t == HALF + NC)     check({tag, " R6 done on time"}, int'(done), 1);
        end
        check_slots(tag);
    endtask

    task automatic t_reset();
        check("R8 reset done", int'(done), 0);
        check("R8 reset valid", int'(out_valid), 0);
    endtask

    task automatic t_single();
        clear_hist(200);
        hist[80] = 1; hist[81] = 3; hist[82] = 6; hist[83] = 3; hist[84] = 1;
        run_stream(0, "single R5");
    endtask

    task automatic load_many();
        clear_hist(400);
        hist[30] = 9;  hist[29] = 4; hist[31] = 4;
        hist[90] = 14; hist[89] = 7;
        hist[150] = 5;
        hist[210] = 20; hist[211] = 11; hist[209] = 11;
        hist[270] = 14; hist[271] = 14;
        hist[330] = 11;
    endtask

    task automatic t_many();
        load_many();
        run_stream(0, "many R4");
    endtask

    task automatic t_close();
        clear_hist(220);
        hist[60] = 8;  hist[70] = 12;   // 10 apart: only 70 kept, R2
        hist[120] = 9; hist[141] = 10;  // 21 apart: both kept, R2
        run_stream(0, "close R2");
    endtask

    task automatic t_plateau();
        clear_hist(200);
        for (int j = 50; j < 100; j++) hist[j] = 7;
        run_stream(0, "plateau R3");
        check("plateau R3 second slot empty", int'(out_valid[1]), 0);
    endtask

    task automatic t_edges();
        clear_hist(100);
        hist[0] = 9; hist[1] = 2; hist[99] = 6; hist[98] = 1;
        run_stream(0, "edges R1");
    endtask

    task automatic t_bubbles();
        load_many();
        run_stream(3, "bubbles R9");
    endtask

    task automatic t_hold_and_restart();
        logic [NC*CW-1:0] crd_snap;
        logic [NC*VW-1:0] cnt_snap;
        logic [NC-1:0]    val_snap;
        crd_snap = out_coord; cnt_snap = out_count; val_snap = out_valid;
        for (int k = 0; k < 10; k++) begin
            in_valid = 1'b1; in_count = VW'(4000 + k); in_coord = CW'(k);
            in_last = k[0];
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0;
        repeat (HALF + NC + 2) @(negedge clk);
        check("R7 done held", int'(done), 1);
        check("R9 late bins ignored valid", int'(out_valid == val_snap), 1);
        check("R9 late bins ignored count", int'(out_count == cnt_snap), 1);
        check("R9 late bins ignored coord", int'(out_coord == crd_snap), 1);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R8 start clears done", int'(done), 0);
        check("R8 start clears slots", int'(out_valid), 0);
        repeat (HALF + NC + 4) @(negedge clk);
        check("R9 idle stream no shift", int'(out_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_many();
        t_close();
        t_plateau();
        t_edges();
        t_bubbles();
        t_hold_and_restart();
        t_single();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule